// File: doc/BRIEF.md
# Key-Locked Function-Select Guard

This block holds an 8-bit function-select value that picks, for each of eight pins, between the plain data path and an alternate peripheral path. Two layers protect that value. The first layer is a 32-bit key register. The second layer is an 8-bit commit mask, and it can only be rewritten after the correct key has been written. The commit mask then decides, bit by bit, which function-select bits a write may change. Reset leaves every bit committed, so function-select is freely writable until software narrows the mask. After that, changing a protected bit takes three steps: write the key, widen the mask, then write the select value.

The block is reached through a simple register port. It has write and read strobes, a 12-bit byte address, and 32-bit data. Read data is registered and appears on the cycle after the read strobe. A bank of 8-bit pad-configuration words (drive, pull, slew and similar) is plain storage. A read-only identification area returns one byte per word. Any other address reads zero, ignores writes and raises a one-cycle error flag.

The lock is a two-state machine. `LK_LOCKED` is the reset state. It moves to `LK_OPEN` on transition KEY_MATCH, which is a write of the key to the lock word. `LK_OPEN` moves back to `LK_LOCKED` on transition KEY_MISMATCH, which is a write of any other value to the lock word. Every other access leaves the state as it is (transition HOLD). In particular, writing the commit mask does not re-lock.

Top module: `gs_keyguard`

## Requirements
- R1: After reset, the lock word (0x520) reads 1, the commit word (0x524) reads 0xFF, function-select (0x420) reads 0 and `func_sel` is 0. Pad word 0 (0x500) reads 0xFF and the other pad words read 0.
- R2: Writing exactly 0x0ACCE551 to the lock word unlocks the block, and the lock word then reads 0.
- R3: Writing any other value to the lock word locks the block (reads 1). Without a lock-word write the lock state never changes, including across commit writes.
- R4: A write to the commit word loads wdata[7:0] only while unlocked. While locked, the write leaves the commit word unchanged.
- R5: A write to function-select changes only the bits whose commit bit is 1; the new value is (old & ~commit) | (wdata[7:0] & commit). `func_sel` shows the new value from the cycle after the write.
- R6: Reads return the current 8-bit value zero-extended to 32 bits, on `rdata` in the cycle after `rd_en`.
- R7: Pad word i sits at 0x500 + 4*i, for i from 0 to 7, and stores wdata[7:0] on a write.
- R8: Identification word k, at 0xFD0 + 4*k for k from 0 to 11, reads byte k of the ID parameter (bits 8k+7..8k). Writes there are ignored and raise no error.
- R9: A read or write at any other address reads 0, changes nothing and sets `err` for exactly the following cycle. An address with a nonzero value in bits [1:0] counts as another address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for an unmapped access |
| func_sel | output | 8 | Current function-select value |

## Verification
A lock state stuck in the wrong state shows up at the very next lock-word read. It also shows up on the next commit write, whose read-back either moves when it should not or stays put when it should move. A corrupted commit mask is visible directly on a commit read. It also shows up on `func_sel` one cycle after the next function-select write, as a protected bit that moved or a committed bit that did not follow the data. Decode faults show up on the access itself as a wrong `err` pulse or nonzero data from an unmapped read.

// File: rtl/gs_keyguard_pkg.sv
package gs_keyguard_pkg;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

    localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

    // word indices (byte address >> 2)
    localparam int FSEL_WORD   = 'h108;
    localparam int PAD_WORD    = 'h140;
    localparam int LOCK_WORD   = 'h148;
    localparam int COMMIT_WORD = 'h149;
    localparam int ID_WORD     = 'h3F4;

    typedef struct packed {
        logic fsel;
        logic lock;
        logic commit;
        logic pad;
        logic id;
        logic bad;
    } sel_t;

endpackage

// File: rtl/gs_addr_decode.sv
module gs_addr_decode
    import gs_keyguard_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_PAD = 8,
    parameter int NUM_ID  = 12,
    localparam int WA     = ADDR_W - 2,
    localparam int PIW    = $clog2(NUM_PAD),
    localparam int IIW    = $clog2(NUM_ID)
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel,
    output logic [PIW-1:0]    pad_idx,
    output logic [IIW-1:0]    id_idx
);

    localparam logic [WA-1:0] FSEL_W   = WA'(FSEL_WORD);
    localparam logic [WA-1:0] LOCK_W   = WA'(LOCK_WORD);
    localparam logic [WA-1:0] COMMIT_W = WA'(COMMIT_WORD);
    localparam logic [WA-1:0] PADB_W   = WA'(PAD_WORD);
    localparam logic [WA-1:0] IDB_W    = WA'(ID_WORD);
    localparam logic [WA-1:0] NPAD_W   = WA'(NUM_PAD);
    localparam logic [WA-1:0] NID_W    = WA'(NUM_ID);

    logic [WA-1:0] word;
    logic [WA-1:0] pad_off;
    logic [WA-1:0] id_off;
    logic          aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign pad_off = word - PADB_W;
    assign id_off  = word - IDB_W;
    assign pad_idx = pad_off[PIW-1:0];
    assign id_idx  = id_off[IIW-1:0];

    always_comb begin
        sel = '0;
        if (!aligned)                sel.bad    = 1'b1;
        else if (word == FSEL_W)     sel.fsel   = 1'b1;
        else if (word == LOCK_W)     sel.lock   = 1'b1;
        else if (word == COMMIT_W)   sel.commit = 1'b1;
        else if (pad_off < NPAD_W)   sel.pad    = 1'b1;
        else if (id_off < NID_W)     sel.id     = 1'b1;
        else                         sel.bad    = 1'b1;
    end

    // R9: exactly one target is chosen for every address
    always_comb begin
        a_r9_one_target: assert ($onehot({sel.fsel, sel.lock, sel.commit,
                                          sel.pad, sel.id, sel.bad}) || $isunknown(addr));
    end

endmodule

// File: rtl/gs_lock_fsm.sv
module gs_lock_fsm
    import gs_keyguard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lock,
    input  logic [31:0] wdata,
    output logic        is_locked
);

    lock_state_e st_q, st_d;
    logic        key_ok;

    assign key_ok = (wdata == UNLOCK_KEY);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_LOCKED: if (wr_lock && key_ok)  st_d = LK_OPEN;    // KEY_MATCH
            LK_OPEN:   if (wr_lock && !key_ok) st_d = LK_LOCKED;  // KEY_MISMATCH
            default:   st_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        is_locked = (st_q == LK_LOCKED);
    end

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wdata == UNLOCK_KEY) |=> !is_locked);

    a_r3_other_value_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wdata != UNLOCK_KEY) |=> is_locked);

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lock |=> $stable(is_locked));

endmodule

// File: rtl/gs_commit_guard.sv
module gs_commit_guard #(
    parameter int              W          = 8,
    parameter logic [W-1:0]    COMMIT_RST = '1,
    parameter logic [W-1:0]    FSEL_RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_locked,
    input  logic         wr_commit,
    input  logic         wr_fsel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] commit_q,
    output logic [W-1:0] fsel_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       commit_q <= COMMIT_RST;
        else if (wr_commit && !is_locked) commit_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fsel_q <= FSEL_RST;
        else if (wr_fsel) fsel_q <= (fsel_q & ~commit_q) | (wdata & commit_q);
    end

    a_r4_locked_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && is_locked) |=> $stable(commit_q));

    a_r4_open_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !is_locked) |=> commit_q == $past(wdata));

    a_r5_protected_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fsel |=> ((fsel_q ^ $past(fsel_q)) & ~$past(commit_q)) == '0);

    a_r5_committed_bits_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fsel |=> ((fsel_q ^ $past(wdata)) & $past(commit_q)) == '0);

    a_r5_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fsel |=> $stable(fsel_q));

endmodule

// File: rtl/gs_keyguard.sv
module gs_keyguard
    import gs_keyguard_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          W        = 8,
    parameter int          NUM_PAD  = 8,
    parameter int          NUM_ID   = 12,
    parameter logic [W-1:0] PAD0_RST = 8'hFF,
    parameter logic [NUM_ID*8-1:0] ID_BYTES = 96'h5AA5_3CC3_0FF0_1234_5678_9ABC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output logic [W-1:0]      func_sel
);

    localparam int PIW = $clog2(NUM_PAD);
    localparam int IIW = $clog2(NUM_ID);

    sel_t           sel;
    logic [PIW-1:0] pad_idx;
    logic [IIW-1:0] id_idx;
    logic           is_locked;
    logic [W-1:0]   commit_q;
    logic [W-1:0]   fsel_q;
    logic [W-1:0]   pad_q [NUM_PAD];
    logic [W-1:0]   pad_rd;
    logic [W-1:0]   id_rd;
    logic [31:0]    rd_mux;

    gs_addr_decode #(.ADDR_W(ADDR_W), .NUM_PAD(NUM_PAD), .NUM_ID(NUM_ID)) u_dec (
        .addr    (addr),
        .sel     (sel),
        .pad_idx (pad_idx),
        .id_idx  (id_idx)
    );

    gs_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lock   (wr_en && sel.lock),
        .wdata     (wdata),
        .is_locked (is_locked)
    );

    gs_commit_guard #(.W(W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_locked (is_locked),
        .wr_commit (wr_en && sel.commit),
        .wr_fsel   (wr_en && sel.fsel),
        .wdata     (wdata[W-1:0]),
        .commit_q  (commit_q),
        .fsel_q    (fsel_q)
    );

    for (genvar i = 0; i < NUM_PAD; i++) begin : g_pad
        localparam logic [W-1:0] RST_V = (i == 0) ? PAD0_RST : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       pad_q[i] <= RST_V;
            else if (wr_en && sel.pad && pad_idx == PIW'(i))  pad_q[i] <= wdata[W-1:0];
        end
    end

    always_comb begin
        pad_rd = '0;
        for (int i = 0; i < NUM_PAD; i++)
            if (pad_idx == PIW'(i)) pad_rd = pad_q[i];
    end

    always_comb begin
        id_rd = '0;
        for (int k = 0; k < NUM_ID; k++)
            if (id_idx == IIW'(k)) id_rd = ID_BYTES[8*k +: 8];
    end

    always_comb begin
        rd_mux = '0;
        if (sel.fsel)        rd_mux[W-1:0] = fsel_q;
        else if (sel.lock)   rd_mux[0]     = is_locked;
        else if (sel.commit) rd_mux[W-1:0] = commit_q;
        else if (sel.pad)    rd_mux[W-1:0] = pad_rd;
        else if (sel.id)     rd_mux[7:0]   = id_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_mux;
            err <= (rd_en || wr_en) && sel.bad;
        end
    end

    assign func_sel = fsel_q;

    a_r9_err_needs_bad_access: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && sel.bad) |=> err);

    a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel.bad) |=> rdata == '0);

    a_r9_no_err_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_en || wr_en) && sel.bad) |=> !err);

    a_r6_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rdata[31:W] == '0);

endmodule

// File: tb/gs_keyguard_tb.sv
`timescale 1ns/1ps
module gs_keyguard_tb;

    localparam logic [31:0] KEY = 32'h0ACC_E551;
    localparam logic [95:0] IDV = 96'h5AA5_3CC3_0FF0_1234_5678_9ABC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [7:0]  func_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model
    bit        m_locked;
    logic [7:0] m_commit, m_fsel;
    logic [7:0] m_pad [8];

    always #10 clk = ~clk;

    gs_keyguard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err), .func_sel(func_sel)
    );

    function automatic logic [7:0] merge_fsel(logic [7:0] old, logic [7:0] c, logic [7:0] w);
        return (old & ~c) | (w & c);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic last_err;

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        last_err = err;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata; e = err;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d; logic e;
        rd(a, d, e);
        chk(d == exp && !e, req, d, exp);
    endtask

    // model-side write
    task automatic mwr(input logic [11:0] a, input logic [31:0] d);
        wr(a, d);
        if (a == 12'h520) m_locked = (d != KEY);
        else if (a == 12'h524) begin if (!m_locked) m_commit = d[7:0]; end
        else if (a == 12'h420) m_fsel = merge_fsel(m_fsel, m_commit, d[7:0]);
        else if (a >= 12'h500 && a < 12'h520) m_pad[(a - 12'h500) >> 2] = d[7:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic e;
        void'($urandom(32'd2024));
        m_locked = 1'b1; m_commit = 8'hFF; m_fsel = 8'h00;
        for (int i = 0; i < 8; i++) m_pad[i] = (i == 0) ? 8'hFF : 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(func_sel == 8'h00 && err == 1'b0, "R1 func_sel/err", {23'd0, err, func_sel}, 32'h0);
        rd_chk(12'h520, 32'h1,  "R1 lock");
        rd_chk(12'h524, 32'hFF, "R1 commit");
        rd_chk(12'h420, 32'h00, "R1 fsel");
        rd_chk(12'h500, 32'hFF, "R1 pad0");
        rd_chk(12'h50C, 32'h00, "R1 pad3");

        // R5 full commit after reset, R6 read timing
        mwr(12'h420, 32'hFFFF_FFA5);
        chk(func_sel == 8'hA5, "R5 full commit", {24'd0, func_sel}, 32'hA5);
        rd_chk(12'h420, 32'hA5, "R6 zero-extended read");

        // R4 commit ignored while locked
        mwr(12'h524, 32'h0F);
        rd_chk(12'h524, 32'hFF, "R4 locked commit ignored");

        // R2 unlock
        mwr(12'h520, KEY);
        rd_chk(12'h520, 32'h0, "R2 unlocked");
        mwr(12'h524, 32'h0F);
        rd_chk(12'h524, 32'h0F, "R4 open commit loads");
        rd_chk(12'h520, 32'h0, "R3 no relock after commit");

        // R5 partial commit
        mwr(12'h420, 32'h5A);
        chk(func_sel == 8'hAA, "R5 masked write", {24'd0, func_sel}, 32'hAA);

        // R3 near-miss key locks
        mwr(12'h520, 32'h0ACC_E550);
        rd_chk(12'h520, 32'h1, "R3 wrong key locks");
        mwr(12'h524, 32'h33);
        rd_chk(12'h524, 32'h0F, "R4 relocked commit ignored");

        // R7 pad storage
        mwr(12'h51C, 32'h5C);
        rd_chk(12'h51C, 32'h5C, "R7 pad7");

        // R8 identification bytes
        rd_chk(12'hFD0, {24'd0, IDV[7:0]},   "R8 id0");
        rd_chk(12'hFFC, {24'd0, IDV[95:88]}, "R8 id11");
        wr(12'hFD0, 32'h77);
        chk(!last_err, "R8 id write no err", {31'd0, last_err}, 32'h0);
        rd_chk(12'hFD0, {24'd0, IDV[7:0]},   "R8 id write ignored");

        // R9 unmapped and misaligned
        rd(12'h424, d, e);
        chk(d == 0 && e, "R9 unmapped read", {e, d[30:0]}, 32'h8000_0000);
        wr(12'h600, 32'hFFFF_FFFF);
        chk(last_err, "R9 unmapped write err", {31'd0, last_err}, 32'h1);
        @(negedge clk);
        chk(!err, "R9 err one cycle", {31'd0, err}, 32'h0);
        wr(12'h421, 32'h00);
        chk(last_err && func_sel == m_fsel, "R9 misaligned ignored", {23'd0, last_err, func_sel}, {23'd0, 1'b1, m_fsel});

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [31:0] v;
            int op;
            op = $urandom_range(0, 4);
            v = $urandom;
            case (op)
                0: begin a = 12'h520; if ($urandom_range(0, 1) == 1) v = KEY; end
                1: a = 12'h524;
                2: a = 12'h420;
                3: a = 12'h500 + 12'(4 * $urandom_range(0, 7));
                default: a = 12'h800 + 12'(4 * $urandom_range(0, 100));
            endcase
            mwr(a, v);
            if (op == 4) chk(last_err, "R9 random unmapped", {31'd0, last_err}, 32'h1);
            chk(func_sel == m_fsel, "R5 random func_sel", {24'd0, func_sel}, {24'd0, m_fsel});
            case (op)
                0: rd_chk(12'h520, {31'd0, m_locked}, "R2 R3 random lock");
                1: rd_chk(12'h524, {24'd0, m_commit}, "R4 random commit");
                2: rd_chk(12'h420, {24'd0, m_fsel},   "R5 random fsel");
                3: rd_chk(a, {24'd0, m_pad[(a - 12'h500) >> 2]}, "R7 random pad");
                default: rd_chk(12'h524, {24'd0, m_commit}, "R9 random no side effect");
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule